// File: doc/BRIEF.md
# Shared Timebase Counter

This block is the free-running up-counter that several capture/compare channels read as their common time reference. Each cycle it decides whether to advance, based on a two-bit source select. Two of the sources are fixed fractions of the system clock, and those fractions depend on whether the core runs in its fast (6-clock) or slow (12-clock) timing mode. A third source is an overflow pulse from a neighbouring timer. The fourth is an asynchronous external count pin, which is brought into the clock domain before use.

Software starts and stops the counter with a run bit. Software can also load the count directly. When the count wraps from all ones to zero, a sticky overflow flag is set. That flag stays set until software clears it. An interrupt request follows the flag while the overflow interrupt enable is set. An optional idle-stop setting freezes the counter and its prescaler while the processor reports idle.

Top module: `shared_timebase`

## Requirements
- R1: After reset, `count` is 0 and both `ovf_flag` and `irq` are 0.
- R2: With `src_sel` = 2'b00, the count advances once every 6 clocks when `slow_core` = 0, or once every 12 clocks when `slow_core` = 1. The first step lands on the 6th (or 12th) running edge.
- R3: With `src_sel` = 2'b01, the count advances once every 2 clocks when `slow_core` = 0, or once every 4 clocks when `slow_core` = 1.
- R4: With `src_sel` = 2'b10, the count advances by one on each clock edge at which `tmr_ovf_pulse` is high.
- R5: With `src_sel` = 2'b11, each falling edge of `ext_cnt_in` advances the count by one. The count changes on the third rising clock edge after the input falls. A rising edge of the input never advances the count.
- R6: While `run_en` is 0, the count holds. The prescaler phase also restarts, so a new run period begins a full division period.
- R7: While `idle_stop_en` and `cpu_idle` are both 1, the count and the prescaler hold. With `idle_stop_en` at 0, `cpu_idle` has no effect.
- R8: An advance from all ones to zero sets `ovf_flag`. The flag is cleared only by `flag_clr`. A wrap in the same cycle as `flag_clr` leaves the flag set.
- R9: `irq` is 1 exactly when `ovf_flag` and `ovf_irq_en` are both 1.
- R10: A load through `cnt_wr_en` takes priority over an advance in the same cycle. That load never sets `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oscillator rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Counting enabled while high |
| src_sel | input | 2 | Count source: 00 slow divide, 01 fast divide, 10 timer overflow, 11 external pin |
| slow_core | input | 1 | 1 selects 12-clock mode divide ratios, 0 selects 6-clock mode ratios |
| idle_stop_en | input | 1 | Allow the idle input to freeze counting |
| cpu_idle | input | 1 | Processor idle indication |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| tmr_ovf_pulse | input | 1 | One-cycle overflow pulse from another timer |
| ext_cnt_in | input | 1 | Asynchronous external count input |
| cnt_wr_en | input | 1 | Load `cnt_wr_data` into the counter |
| cnt_wr_data | input | WIDTH | Value to load |
| flag_clr | input | 1 | Software clear of the overflow flag |
| count | output | WIDTH | Current timebase value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The count, the overflow flag and any load each appear one clock edge after the decision that causes them, because each is a single register. `irq` follows the flag combinationally, in the same cycle. The external pin is the exception: it passes through three registers, so its effect lands on the third rising edge. The bench checks that the count is still unchanged after the second edge and has moved after the third.

All inputs are driven, and all outputs sampled, on falling clock edges. A run window of N cycles therefore covers exactly N rising edges. The expected count for such a window is N divided by the division period, rounded down, which relies on the prescaler restarting whenever the counter is stopped.

// File: rtl/shared_timebase.sv
module shared_timebase #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [1:0]       src_sel,
  input  logic             slow_core,
  input  logic             idle_stop_en,
  input  logic             cpu_idle,
  input  logic             ovf_irq_en,
  input  logic             tmr_ovf_pulse,
  input  logic             ext_cnt_in,
  input  logic             cnt_wr_en,
  input  logic [WIDTH-1:0] cnt_wr_data,
  input  logic             flag_clr,
  output logic [WIDTH-1:0] count,
  output logic             ovf_flag,
  output logic             irq
);
  localparam int DIV_FAST = 6;
  localparam int DIV_SLOW = 12;
  localparam int DW = $clog2(DIV_SLOW);

  logic [DW-1:0] div_cnt;
  logic [DW-1:0] div_last;
  logic [2:0]    ext_sync;
  logic          active, tick_slow, tick_fast, ext_fall, tick, inc, wrap;

  assign div_last  = slow_core ? DW'(DIV_SLOW - 1) : DW'(DIV_FAST - 1);
  assign active    = run_en & ~(idle_stop_en & cpu_idle);
  assign tick_slow = (div_cnt >= div_last);
  assign tick_fast = slow_core ? (div_cnt[1:0] == 2'd3) : div_cnt[0];
  assign ext_fall  = ext_sync[2] & ~ext_sync[1];

  always_comb begin
    case (src_sel)
      2'b00:   tick = tick_slow;
      2'b01:   tick = tick_fast;
      2'b10:   tick = tmr_ovf_pulse;
      default: tick = ext_fall;
    endcase
  end

  assign inc  = active & tick;
  assign wrap = inc & (&count) & ~cnt_wr_en;
  assign irq  = ovf_flag & ovf_irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_en)
      div_cnt <= '0;
    else if (active)
      div_cnt <= tick_slow ? '0 : div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[1:0], ext_cnt_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         count <= '0;
    else if (cnt_wr_en) count <= cnt_wr_data;
    else if (inc)       count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (wrap)     ovf_flag <= 1'b1;
    else if (flag_clr) ovf_flag <= 1'b0;
  end

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_wr_en) |=> $stable(count)); // R6
  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_stop_en && cpu_idle && !cnt_wr_en) |=> $stable(count)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag); // R8
  AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr_en && (&count)) |=> (count != '0 || ovf_flag)); // R8
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> (count == $past(cnt_wr_data))); // R10
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr_en |=> (count == $past(count) || count == $past(count) + WIDTH'(1))); // R2
endmodule

// File: tb/shared_timebase_tb.sv
module shared_timebase_tb_top;
  logic clk = 0, rst_n = 0;
  logic run_en = 0, slow_core = 0, idle_stop_en = 0, cpu_idle = 0, ovf_irq_en = 0;
  logic tmr_ovf_pulse = 0, ext_cnt_in = 0, cnt_wr_en = 0, flag_clr = 0;
  logic [1:0] src_sel = 0;
  logic [15:0] cnt_wr_data = 0;
  logic [15:0] count;
  logic ovf_flag, irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shared_timebase #(.WIDTH(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel), .slow_core(slow_core),
    .idle_stop_en(idle_stop_en), .cpu_idle(cpu_idle), .ovf_irq_en(ovf_irq_en),
    .tmr_ovf_pulse(tmr_ovf_pulse), .ext_cnt_in(ext_cnt_in), .cnt_wr_en(cnt_wr_en),
    .cnt_wr_data(cnt_wr_data), .flag_clr(flag_clr), .count(count), .ovf_flag(ovf_flag), .irq(irq));

  // {sel[1:0], slow, pulse, cycles[7:0], expected[15:0]}
  localparam int NV = 10;
  localparam logic [27:0] VEC [NV] = '{
    {2'b00, 1'b0, 1'b0, 8'd60, 16'd10},
    {2'b00, 1'b1, 1'b0, 8'd60, 16'd5},
    {2'b00, 1'b0, 1'b0, 8'd11, 16'd1},
    {2'b00, 1'b1, 1'b0, 8'd11, 16'd0},
    {2'b01, 1'b0, 1'b0, 8'd9,  16'd4},
    {2'b01, 1'b1, 1'b0, 8'd9,  16'd2},
    {2'b01, 1'b1, 1'b0, 8'd40, 16'd10},
    {2'b10, 1'b0, 1'b1, 8'd25, 16'd25},
    {2'b10, 1'b1, 1'b0, 8'd25, 16'd0},
    {2'b11, 1'b0, 1'b0, 8'd30, 16'd0}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk); cnt_wr_en = 1; cnt_wr_data = v;
    @(negedge clk); cnt_wr_en = 0;
  endtask

  task automatic run_for(input int n);
    run_en = 1;
    repeat (n) @(negedge clk);
    run_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 count", count, 16'd0);
    check("R1 flag", {15'd0, ovf_flag}, 16'd0);
    check("R1 irq", {15'd0, irq}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      load(16'd0);
      src_sel = VEC[i][27:26]; slow_core = VEC[i][25]; tmr_ovf_pulse = VEC[i][24];
      run_for(int'(VEC[i][23:16]));
      tmr_ovf_pulse = 0;
      check($sformatf("R2 R3 R4 vector %0d", i), count, VEC[i][15:0]);
    end

    // R6: stopped counter ignores pulses; prescaler restarts
    load(16'd7); src_sel = 2'b10; tmr_ovf_pulse = 1;
    repeat (10) @(negedge clk);
    tmr_ovf_pulse = 0;
    check("R6 hold", count, 16'd7);
    load(16'd0); src_sel = 2'b00; slow_core = 0;
    run_for(4); @(negedge clk); run_for(3);
    check("R6 prescaler restart", count, 16'd0);

    // R7: idle stop
    load(16'd0); src_sel = 2'b01; idle_stop_en = 1; cpu_idle = 1;
    run_for(20);
    check("R7 frozen", count, 16'd0);
    idle_stop_en = 0;
    run_for(20);
    check("R7 idle ignored", count, 16'd10);
    cpu_idle = 0;

    // R5: external falling edge, three-edge latency
    load(16'd0); src_sel = 2'b11; run_en = 1;
    ext_cnt_in = 1; repeat (5) @(negedge clk);
    check("R5 rising ignored", count, 16'd0);
    ext_cnt_in = 0; repeat (2) @(negedge clk);
    check("R5 before third edge", count, 16'd0);
    @(negedge clk);
    check("R5 third edge", count, 16'd1);
    for (int k = 0; k < 4; k++) begin
      ext_cnt_in = 1; repeat (3) @(negedge clk);
      ext_cnt_in = 0; repeat (3) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check("R5 several edges", count, 16'd5);
    run_en = 0;

    // R8 R9: wrap, sticky flag, interrupt gating
    load(16'hFFFE); src_sel = 2'b10; tmr_ovf_pulse = 1; ovf_irq_en = 0;
    run_for(2); tmr_ovf_pulse = 0;
    check("R8 wrap count", count, 16'd0);
    check("R8 flag set", {15'd0, ovf_flag}, 16'd1);
    check("R9 irq masked", {15'd0, irq}, 16'd0);
    ovf_irq_en = 1; #1;
    check("R9 irq raised", {15'd0, irq}, 16'd1);
    tmr_ovf_pulse = 1; run_for(5); tmr_ovf_pulse = 0;
    check("R8 flag sticky", {15'd0, ovf_flag}, 16'd1);
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    check("R8 flag cleared", {15'd0, ovf_flag}, 16'd0);
    check("R9 irq dropped", {15'd0, irq}, 16'd0);
    load(16'hFFFF); tmr_ovf_pulse = 1; flag_clr = 1;
    run_for(1); tmr_ovf_pulse = 0; flag_clr = 0;
    check("R8 set beats clear", {15'd0, ovf_flag}, 16'd1);
    flag_clr = 1; @(negedge clk); flag_clr = 0;

    // R10: load beats increment and never flags
    load(16'hFFFF); tmr_ovf_pulse = 1; run_en = 1;
    cnt_wr_en = 1; cnt_wr_data = 16'h1234;
    @(negedge clk);
    cnt_wr_en = 0; run_en = 0; tmr_ovf_pulse = 0;
    check("R10 load wins", count, 16'h1234);
    check("R10 no flag", {15'd0, ovf_flag}, 16'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule